// File: doc/BRIEF.md
# Century calendar clock counter

This block keeps wall-clock time and date as seven separate binary fields: second, minute, hour, day of month, month, year within the century, and century. It has no divider of its own. An external base timer supplies a one-cycle pulse once per second, and each pulse advances the calendar by exactly one second. Carries ripple from seconds up to the century within that same clock cycle. Month lengths are built in. The Gregorian leap rule is worked out from the year and century fields.

Software or a neighbouring block can preset every field at once through a load strobe. The valid range ends at 23:59:59 on 31 December 2799. A tick at that instant leaves the fields unchanged and raises a sticky end-of-range flag. The flag stays set until the next load.

Top module: `century_calendar`

## Requirements
- R1: After reset the fields read 2000-01-01 00:00:00. This means century 20, year 0, month 1, day 1, and hour, minute and second all 0. The end-of-range flag is 0.
- R2: The fields change only in the cycle after a tick or a load. With neither input asserted, every output holds its value.
- R3: Each tick advances the second. The second and the minute each wrap from 59 to 0 and carry into the next field. The hour wraps from 23 to 0 and carries into the day.
- R4: Months 1, 3, 5, 7, 8, 10 and 12 have 31 days, months 4, 6, 9 and 11 have 30, and February has 28 in a common year. On a carry past the last day, the day returns to 1 and the month advances. The month wraps from 12 to 1 and carries into the year.
- R5: February has 29 days in a leap year. A year is a leap year in either of two cases. In the first, the year field is nonzero and divisible by 4. In the second, the year field is 0 and the century is divisible by 4. So 2000 and 2400 are leap years, and 2100 is not.
- R6: The year field wraps from 99 to 0 and increments the century.
- R7: A tick at 2799-12-31 23:59:59 leaves all fields unchanged and sets the end-of-range flag. The flag stays set through any later ticks until a load.
- R8: A load writes all seven fields from the load inputs in the next cycle and clears the end-of-range flag. A tick in the same cycle as a load is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | One-second pulse from the base timer |
| load_i | input | 1 | Preset strobe for all fields |
| ld_sec_i | input | 6 | Preset second, 0..59 |
| ld_min_i | input | 6 | Preset minute, 0..59 |
| ld_hour_i | input | 5 | Preset hour, 0..23 |
| ld_day_i | input | 5 | Preset day, 1..month length |
| ld_mon_i | input | 4 | Preset month, 1..12 |
| ld_year_i | input | 7 | Preset year within century, 0..99 |
| ld_cent_i | input | 5 | Preset century, 0..27 |
| sec_o | output | 6 | Current second |
| min_o | output | 6 | Current minute |
| hour_o | output | 5 | Current hour |
| day_o | output | 5 | Current day of month |
| mon_o | output | 4 | Current month |
| year_o | output | 7 | Current year within century |
| cent_o | output | 5 | Current century |
| end_o | output | 1 | Sticky end-of-range flag |

## Verification
The range assertions on the day, month and hour fields assume that every load carries a valid calendar date and time, with a day no larger than the length of its month. The block does not check loaded values. The stimulus loads only real dates, chosen next to month, leap-day, century and end-of-range boundaries. It then advances the calendar with single ticks, bursts of consecutive ticks and sparse patterns. A load and a tick are driven in the same cycle only where the bench tests their priority.

// File: rtl/cal_pkg.sv
package cal_pkg;
  localparam int SEC_W  = 6;
  localparam int MIN_W  = 6;
  localparam int HOUR_W = 5;
  localparam int DAY_W  = 5;
  localparam int MON_W  = 4;
  localparam int YEAR_W = 7;
  localparam int CENT_W = 5;

  // Leap rule split over the two stored fields
  function automatic logic leap_of(input logic [YEAR_W-1:0] yr,
                                   input logic [CENT_W-1:0] cen);
    if (yr != '0) return (yr[1:0] == 2'b00);
    else          return (cen[1:0] == 2'b00);
  endfunction

  function automatic logic [DAY_W-1:0] days_in(input logic [MON_W-1:0] mon,
                                               input logic leap);
    case (mon)
      4'd4, 4'd6, 4'd9, 4'd11: return DAY_W'(30);
      4'd2:                    return leap ? DAY_W'(29) : DAY_W'(28);
      default:                 return DAY_W'(31);
    endcase
  endfunction
endpackage

// File: rtl/cal_wrap_ctr.sv
module cal_wrap_ctr #(
  parameter int W    = 6,
  parameter int LOWV = 0,
  parameter int RSTV = 0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] ld_val,
  input  logic         inc,
  input  logic [W-1:0] lim,
  output logic [W-1:0] q,
  output logic         at_lim
);
  assign at_lim = (q == lim);

  always_ff @(posedge clk) begin
    if (!rst_n)      q <= W'(RSTV);
    else if (load)   q <= ld_val;
    else if (inc)    q <= at_lim ? W'(LOWV) : q + W'(1);
  end
endmodule

// File: rtl/cal_time_unit.sv
module cal_time_unit
  import cal_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              step,
  input  logic [SEC_W-1:0]  ld_sec,
  input  logic [MIN_W-1:0]  ld_min,
  input  logic [HOUR_W-1:0] ld_hour,
  output logic [SEC_W-1:0]  sec,
  output logic [MIN_W-1:0]  min,
  output logic [HOUR_W-1:0] hour,
  output logic              day_wrap
);
  logic sec_top, min_top, hour_top;

  cal_wrap_ctr #(.W(SEC_W)) u_sec (
    .clk(clk), .rst_n(rst_n), .load(load), .ld_val(ld_sec),
    .inc(step), .lim(SEC_W'(59)), .q(sec), .at_lim(sec_top));

  cal_wrap_ctr #(.W(MIN_W)) u_min (
    .clk(clk), .rst_n(rst_n), .load(load), .ld_val(ld_min),
    .inc(step & sec_top), .lim(MIN_W'(59)), .q(min), .at_lim(min_top));

  cal_wrap_ctr #(.W(HOUR_W)) u_hour (
    .clk(clk), .rst_n(rst_n), .load(load), .ld_val(ld_hour),
    .inc(step & sec_top & min_top), .lim(HOUR_W'(23)), .q(hour), .at_lim(hour_top));

  assign day_wrap = sec_top & min_top & hour_top;
endmodule

// File: rtl/cal_date_unit.sv
module cal_date_unit
  import cal_pkg::*;
#(
  parameter int LAST_CENT  = 27,
  parameter int RESET_CENT = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              step,
  input  logic [DAY_W-1:0]  ld_day,
  input  logic [MON_W-1:0]  ld_mon,
  input  logic [YEAR_W-1:0] ld_year,
  input  logic [CENT_W-1:0] ld_cent,
  output logic [DAY_W-1:0]  day,
  output logic [MON_W-1:0]  mon,
  output logic [YEAR_W-1:0] year,
  output logic [CENT_W-1:0] cent,
  output logic              last_date
);
  logic day_top, mon_top, year_top, cent_top;
  logic [DAY_W-1:0] mlen;

  assign mlen = days_in(mon, leap_of(year, cent));

  cal_wrap_ctr #(.W(DAY_W), .LOWV(1), .RSTV(1)) u_day (
    .clk(clk), .rst_n(rst_n), .load(load), .ld_val(ld_day),
    .inc(step), .lim(mlen), .q(day), .at_lim(day_top));

  cal_wrap_ctr #(.W(MON_W), .LOWV(1), .RSTV(1)) u_mon (
    .clk(clk), .rst_n(rst_n), .load(load), .ld_val(ld_mon),
    .inc(step & day_top), .lim(MON_W'(12)), .q(mon), .at_lim(mon_top));

  cal_wrap_ctr #(.W(YEAR_W)) u_year (
    .clk(clk), .rst_n(rst_n), .load(load), .ld_val(ld_year),
    .inc(step & day_top & mon_top), .lim(YEAR_W'(99)), .q(year), .at_lim(year_top));

  cal_wrap_ctr #(.W(CENT_W), .RSTV(RESET_CENT)) u_cent (
    .clk(clk), .rst_n(rst_n), .load(load), .ld_val(ld_cent),
    .inc(step & day_top & mon_top & year_top), .lim(CENT_W'(LAST_CENT)),
    .q(cent), .at_lim(cent_top));

  assign last_date = day_top & mon_top & year_top & cent_top;
endmodule

// File: rtl/century_calendar.sv
module century_calendar
  import cal_pkg::*;
#(
  parameter int LAST_CENT  = 27,
  parameter int RESET_CENT = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              load_i,
  input  logic [SEC_W-1:0]  ld_sec_i,
  input  logic [MIN_W-1:0]  ld_min_i,
  input  logic [HOUR_W-1:0] ld_hour_i,
  input  logic [DAY_W-1:0]  ld_day_i,
  input  logic [MON_W-1:0]  ld_mon_i,
  input  logic [YEAR_W-1:0] ld_year_i,
  input  logic [CENT_W-1:0] ld_cent_i,
  output logic [SEC_W-1:0]  sec_o,
  output logic [MIN_W-1:0]  min_o,
  output logic [HOUR_W-1:0] hour_o,
  output logic [DAY_W-1:0]  day_o,
  output logic [MON_W-1:0]  mon_o,
  output logic [YEAR_W-1:0] year_o,
  output logic [CENT_W-1:0] cent_o,
  output logic              end_o
);
  logic day_wrap, last_date;
  logic halt_evt;   // tick at the final second of the range
  logic adv_evt;    // tick that moves the clock
  logic day_evt;    // tick that carries into the date

  assign halt_evt = tick_i & ~load_i & day_wrap & last_date;
  assign adv_evt  = tick_i & ~load_i & ~halt_evt;
  assign day_evt  = adv_evt & day_wrap;

  cal_time_unit u_time (
    .clk(clk), .rst_n(rst_n), .load(load_i), .step(adv_evt),
    .ld_sec(ld_sec_i), .ld_min(ld_min_i), .ld_hour(ld_hour_i),
    .sec(sec_o), .min(min_o), .hour(hour_o), .day_wrap(day_wrap));

  cal_date_unit #(.LAST_CENT(LAST_CENT), .RESET_CENT(RESET_CENT)) u_date (
    .clk(clk), .rst_n(rst_n), .load(load_i), .step(day_evt),
    .ld_day(ld_day_i), .ld_mon(ld_mon_i), .ld_year(ld_year_i), .ld_cent(ld_cent_i),
    .day(day_o), .mon(mon_o), .year(year_o), .cent(cent_o), .last_date(last_date));

  always_ff @(posedge clk) begin
    if (!rst_n)        end_o <= 1'b0;
    else if (load_i)   end_o <= 1'b0;
    else if (halt_evt) end_o <= 1'b1;
  end
endmodule

// File: rtl/cal_checker.sv
module cal_checker
  import cal_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              tick_i,
  input logic              load_i,
  input logic              halt_evt,
  input logic [SEC_W-1:0]  ld_sec_i,
  input logic [DAY_W-1:0]  ld_day_i,
  input logic [CENT_W-1:0] ld_cent_i,
  input logic [SEC_W-1:0]  sec_o,
  input logic [MIN_W-1:0]  min_o,
  input logic [HOUR_W-1:0] hour_o,
  input logic [DAY_W-1:0]  day_o,
  input logic [MON_W-1:0]  mon_o,
  input logic [YEAR_W-1:0] year_o,
  input logic [CENT_W-1:0] cent_o,
  input logic              end_o
);
  AST_TIME_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_o <= 59) && (min_o <= 59) && (hour_o <= 23)); // R3

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && !load_i) |=> ($stable(sec_o) && $stable(min_o) && $stable(hour_o) &&
                              $stable(day_o) && $stable(mon_o) && $stable(year_o) &&
                              $stable(cent_o) && $stable(end_o))); // R2

  AST_SHORT_MONTH: assert property (@(posedge clk) disable iff (!rst_n)
    (mon_o == 4 || mon_o == 6 || mon_o == 9 || mon_o == 11) |-> (day_o <= 30)); // R4

  AST_MONTH_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (mon_o >= 1) && (mon_o <= 12) && (day_o >= 1)); // R4

  AST_LEAP_DAY: assert property (@(posedge clk) disable iff (!rst_n)
    (mon_o == 2 && day_o == 29) |->
      ((year_o != 0 && year_o % 4 == 0) || (year_o == 0 && cent_o % 4 == 0))); // R5

  AST_END_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    halt_evt |=> (end_o && $stable(sec_o) && $stable(day_o) && $stable(cent_o))); // R7

  AST_END_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (end_o && !load_i) |=> end_o); // R7

  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (!end_o && sec_o == $past(ld_sec_i) && day_o == $past(ld_day_i) &&
                cent_o == $past(ld_cent_i))); // R8
endmodule

bind century_calendar cal_checker u_chk (
  .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .load_i(load_i), .halt_evt(halt_evt),
  .ld_sec_i(ld_sec_i), .ld_day_i(ld_day_i), .ld_cent_i(ld_cent_i),
  .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o), .day_o(day_o), .mon_o(mon_o),
  .year_o(year_o), .cent_o(cent_o), .end_o(end_o));

// File: tb/sim_century_calendar.sv
module sim_century_calendar;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_i = 1'b0, load_i = 1'b0;
  logic [5:0] ld_sec_i = '0, ld_min_i = '0;
  logic [4:0] ld_hour_i = '0, ld_day_i = '0, ld_cent_i = '0;
  logic [3:0] ld_mon_i = '0;
  logic [6:0] ld_year_i = '0;
  logic [5:0] sec_o, min_o;
  logic [4:0] hour_o, day_o, cent_o;
  logic [3:0] mon_o;
  logic [6:0] year_o;
  logic end_o;

  int checks = 0, fails = 0;
  bit done = 0;
  string phase = "R1";

  always #2 clk = ~clk;

  century_calendar u0 (.*);

  // Behavioural reference: full year number, plain integers
  int m_s, m_mi, m_h, m_d, m_mo, m_y, m_end;

  function automatic int mdays(int y, int mo);
    int t[12] = '{31,28,31,30,31,30,31,31,30,31,30,31};
    bit lp = ((y % 4 == 0) && (y % 100 != 0)) || (y % 400 == 0);
    if (mo == 2 && lp) return 29;
    return t[mo-1];
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_s = 0; m_mi = 0; m_h = 0; m_d = 1; m_mo = 1; m_y = 2000; m_end = 0;
    end else if (load_i) begin
      m_s = ld_sec_i; m_mi = ld_min_i; m_h = ld_hour_i; m_d = ld_day_i;
      m_mo = ld_mon_i; m_y = ld_cent_i * 100 + ld_year_i; m_end = 0;
    end else if (tick_i) begin
      if (m_y == 2799 && m_mo == 12 && m_d == 31 && m_h == 23 && m_mi == 59 && m_s == 59)
        m_end = 1;
      else begin
        m_s++;
        if (m_s == 60) begin m_s = 0; m_mi++; end
        if (m_mi == 60) begin m_mi = 0; m_h++; end
        if (m_h == 24) begin m_h = 0; m_d++; end
        if (m_d > mdays(m_y, m_mo)) begin m_d = 1; m_mo++; end
        if (m_mo == 13) begin m_mo = 1; m_y++; end
      end
    end
  end

  // Compare against the model on every falling edge once reset is over
  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (sec_o != m_s || min_o != m_mi || hour_o != m_h || day_o != m_d ||
          mon_o != m_mo || year_o != m_y % 100 || cent_o != m_y / 100 || end_o != m_end) begin
        fails++;
        $display("FAIL %s: got %0d%02d-%0d-%0d %0d:%0d:%0d end=%0d expected %0d-%0d-%0d %0d:%0d:%0d end=%0d",
                 phase, cent_o, year_o, mon_o, day_o, hour_o, min_o, sec_o, end_o,
                 m_y, m_mo, m_d, m_h, m_mi, m_s, m_end);
      end
    end
  end

  task automatic expect_dt(string req, int y, int mo, int d, int h, int mi, int s, int e);
    checks++;
    if (cent_o * 100 + year_o != y || mon_o != mo || day_o != d || hour_o != h ||
        min_o != mi || sec_o != s || end_o != e) begin
      fails++;
      $display("FAIL %s: got %0d-%0d-%0d %0d:%0d:%0d end=%0d expected %0d-%0d-%0d %0d:%0d:%0d end=%0d",
               req, cent_o * 100 + year_o, mon_o, day_o, hour_o, min_o, sec_o, end_o,
               y, mo, d, h, mi, s, e);
    end
  endtask

  task automatic load_dt(int y, int mo, int d, int h, int mi, int s, bit with_tick);
    @(negedge clk);
    load_i = 1; tick_i = with_tick;
    ld_cent_i = 5'(y / 100); ld_year_i = 7'(y % 100); ld_mon_i = 4'(mo);
    ld_day_i = 5'(d); ld_hour_i = 5'(h); ld_min_i = 6'(mi); ld_sec_i = 6'(s);
    @(negedge clk);
    load_i = 0; tick_i = 0;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tick_i = 1;
    end
    @(negedge clk);
    tick_i = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    phase = "R1"; expect_dt("R1", 2000, 1, 1, 0, 0, 0, 0);

    phase = "R2"; idle(5); expect_dt("R2", 2000, 1, 1, 0, 0, 0, 0);

    phase = "R3"; load_dt(2023, 6, 30, 22, 0, 0, 0);
    ticks(7300); expect_dt("R3", 2023, 7, 1, 0, 1, 40, 0);
    phase = "R3"; load_dt(2023, 12, 31, 23, 59, 50, 0);
    ticks(15); expect_dt("R3", 2024, 1, 1, 0, 0, 5, 0);

    phase = "R4"; load_dt(2023, 4, 30, 23, 59, 59, 0);
    ticks(1); expect_dt("R4", 2023, 5, 1, 0, 0, 0, 0);
    load_dt(2023, 2, 28, 23, 59, 59, 0);
    ticks(1); expect_dt("R4", 2023, 3, 1, 0, 0, 0, 0);

    phase = "R5"; load_dt(2024, 2, 28, 23, 59, 59, 0);
    ticks(1); expect_dt("R5", 2024, 2, 29, 0, 0, 0, 0);
    load_dt(2000, 2, 28, 23, 59, 59, 0);
    ticks(1); expect_dt("R5", 2000, 2, 29, 0, 0, 0, 0);
    load_dt(2100, 2, 28, 23, 59, 59, 0);
    ticks(1); expect_dt("R5", 2100, 3, 1, 0, 0, 0, 0);
    load_dt(2400, 2, 29, 23, 59, 59, 0);
    ticks(1); expect_dt("R5", 2400, 3, 1, 0, 0, 0, 0);

    phase = "R6"; load_dt(2099, 12, 31, 23, 59, 59, 0);
    ticks(1); expect_dt("R6", 2100, 1, 1, 0, 0, 0, 0);

    phase = "R2";
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      tick_i = (i % 3 == 0) || (i % 7 == 0);
    end
    @(negedge clk); tick_i = 0;

    phase = "R7"; load_dt(2799, 12, 31, 23, 59, 58, 0);
    ticks(1); expect_dt("R7", 2799, 12, 31, 23, 59, 59, 0);
    ticks(1); expect_dt("R7", 2799, 12, 31, 23, 59, 59, 1);
    ticks(4); idle(3); expect_dt("R7", 2799, 12, 31, 23, 59, 59, 1);

    phase = "R8"; load_dt(2500, 7, 15, 12, 30, 45, 1);
    expect_dt("R8", 2500, 7, 15, 12, 30, 45, 0);
    ticks(1); expect_dt("R8", 2500, 7, 15, 12, 30, 46, 0);

    idle(2);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: got no completion expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule